// File: doc/BRIEF.md
# Exception Handler Vector Selector

This block works out the address of the first handler instruction when a processor core takes an exception or comes out of a boot request. Each cycle it looks at a bit vector of exception-class requests and a boot request. When any of them is set, it picks one target address. The choice depends on three mode bits captured before exception entry: the bootstrap-vector select, the exception-level flag and the vectored-interrupt enable. It also depends on a programmable 32-bit exception base. The block registers that address and raises a one-cycle redirect strobe in the next cycle. The fetch stage uses the strobe to load its program counter.

The block also provides the next two sequential fetch addresses after the handler address, so the fetch pipeline can be filled without its own adders. It does not update any architectural state, and it does not arbitrate interrupts or look up translations. Its only job is to select a base and an offset and add them.

The class request bits are assigned as follows:
- bit 0: translation refill
- bit 1: interrupt
- bit 2: arithmetic overflow
- bit 3 and any higher bit: general exception

Top module: `exc_vector_sel`

## Requirements
- R1: When `boot_req_i` is 1, the next registered handler address is 0xBFC00000, whatever the class requests, mode bits and base are.
- R2: When several class request bits are set and no boot request is present, the lowest set bit index decides the class. Bit 0 is refill, bit 1 is interrupt, bit 2 is overflow, and bit 3 is general.
- R3: A refill request selects aligned base + 0x000 when `exl_prev_i` is 0. It selects aligned base + 0x180 when `exl_prev_i` is 1.
- R4: An interrupt request selects aligned base + 0x200 when `ivec_en_i` is 1. It selects aligned base + 0x180 when `ivec_en_i` is 0.
- R5: An overflow request selects the fixed address 0xBFC00200 when `bev_i` is 1, regardless of the base. It selects aligned base + 0x180 when `bev_i` is 0.
- R6: A general request selects aligned base + 0x180. `bev_i`, `exl_prev_i` and `ivec_en_i` have no effect on it.
- R7: Bits 11:0 of `exc_base_i` are treated as zero when the target is formed.
- R8: `redirect_o` is 1 in exactly the cycle after each cycle that has a boot or class request, and 0 otherwise. In that same cycle `handler_pc_o` takes the new target, and it holds its value while no request arrives.
- R9: `fetch_pc1_o` always equals `handler_pc_o` + 4, and `fetch_pc2_o` always equals `handler_pc_o` + 8.
- R10: While reset is held, `redirect_o` is 0 and `handler_pc_o` is 0xBFC00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_req_i | input | 1 | Boot request, highest priority |
| cls_req_i | input | 4 | Exception-class request bits |
| bev_i | input | 1 | Bootstrap-vector select |
| exl_prev_i | input | 1 | Exception-level flag as it was before entry |
| ivec_en_i | input | 1 | Vectored-interrupt enable |
| exc_base_i | input | 32 | Programmable exception base |
| handler_pc_o | output | 32 | Registered handler address |
| fetch_pc1_o | output | 32 | Handler address + 4 |
| fetch_pc2_o | output | 32 | Handler address + 8 |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |

## Verification
A boot request and any mix of class requests can arrive in the same cycle. Several class requests can also arrive together, which brings the priority ordering into play. The bench drives these collisions on purpose: boot together with all four classes, and class combinations together with mode bits that would change the losing class's offset. It then compares the registered address against a behavioural model one cycle later. A random phase keeps both kinds of collision occurring alongside back-to-back requests, so that strobe timing is exercised under the same conditions.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam int unsigned CLS_REFILL = 0;
  localparam int unsigned CLS_IRQ    = 1;
  localparam int unsigned CLS_OVF    = 2;
  localparam int unsigned CLS_GEN    = 3;
  localparam int unsigned MIN_CLS    = 4;
endpackage

// File: rtl/exc_prio_enc.sv
module exc_prio_enc #(
  parameter int unsigned NUM_CLS = 4
) (
  input  logic [NUM_CLS-1:0] req_i,
  output logic [NUM_CLS-1:0] grant_o
);
  // lowest index wins: each bit passes only if all lower bits are clear
  for (genvar g = 0; g < NUM_CLS; g++) begin : g_grant
    if (g == 0) begin : g_first
      assign grant_o[g] = req_i[g];
    end else begin : g_rest
      assign grant_o[g] = req_i[g] & ~(|req_i[g-1:0]);
    end
  end
endmodule

// File: rtl/exc_target_calc.sv
module exc_target_calc
  import exc_vec_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 32,
  parameter int unsigned        NUM_CLS    = 4,
  parameter int unsigned        ALIGN_BITS = 12,
  parameter logic [ADDR_W-1:0]  BOOT_VEC   = 32'hBFC0_0000,
  parameter logic [ADDR_W-1:0]  BEV_OVF    = 32'hBFC0_0200,
  parameter logic [ALIGN_BITS-1:0] OFF_GEN    = 12'h180,
  parameter logic [ALIGN_BITS-1:0] OFF_REFILL = 12'h000,
  parameter logic [ALIGN_BITS-1:0] OFF_IVEC   = 12'h200
) (
  input  logic [NUM_CLS-1:0] grant_i,
  input  logic               boot_i,
  input  logic               bev_i,
  input  logic               exl_prev_i,
  input  logic               ivec_en_i,
  input  logic [ADDR_W-1:0]  base_i,
  output logic [ADDR_W-1:0]  target_o
);
  localparam int unsigned HI_W = ADDR_W - ALIGN_BITS;

  logic [ADDR_W-1:0]     base_al;
  logic [ALIGN_BITS-1:0] off;
  logic [ADDR_W-1:0]     sum;

  assign base_al = {base_i[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};

  always_comb begin
    off = OFF_GEN;
    if (grant_i[CLS_REFILL] && !exl_prev_i) off = OFF_REFILL;
    if (grant_i[CLS_IRQ] && ivec_en_i)      off = OFF_IVEC;
  end

  assign sum = base_al + {{HI_W{1'b0}}, off};

  always_comb begin
    target_o = sum;
    if (grant_i[CLS_OVF] && bev_i) target_o = BEV_OVF;
    if (boot_i)                    target_o = BOOT_VEC;
  end
endmodule

// File: rtl/exc_vec_reg.sv
module exc_vec_reg #(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       INSN_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC   = 32'hBFC0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] pc1_o,
  output logic [ADDR_W-1:0] pc2_o,
  output logic              redirect_o
);
  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(INSN_BYTES);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INSN_BYTES);

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              red_q, red_d;

  always_comb begin
    pc_d  = pc_q;
    red_d = load_i;
    if (load_i) pc_d = target_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      red_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      red_q <= red_d;
    end
  end

  assign pc_o       = pc_q;
  assign pc1_o      = pc_q + STEP1;
  assign pc2_o      = pc_q + STEP2;
  assign redirect_o = red_q;

  a_r8_strobe_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> redirect_o);
  a_r8_strobe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> !redirect_o);
  a_r8_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(pc_o));
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_vec_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned NUM_CLS    = 4,
  parameter int unsigned ALIGN_BITS = 12,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boot_req_i,
  input  logic [NUM_CLS-1:0] cls_req_i,
  input  logic               bev_i,
  input  logic               exl_prev_i,
  input  logic               ivec_en_i,
  input  logic [ADDR_W-1:0]  exc_base_i,
  output logic [ADDR_W-1:0]  handler_pc_o,
  output logic [ADDR_W-1:0]  fetch_pc1_o,
  output logic [ADDR_W-1:0]  fetch_pc2_o,
  output logic               redirect_o
);
  localparam logic [ADDR_W-1:0] BOOT_VEC = 32'hBFC0_0000;
  localparam logic [ADDR_W-1:0] BEV_OVF  = 32'hBFC0_0200;

  logic [NUM_CLS-1:0] grant;
  logic [ADDR_W-1:0]  target;
  logic               load;

  assign load = boot_req_i | (|cls_req_i);

  exc_prio_enc #(.NUM_CLS(NUM_CLS)) i_prio (
    .req_i   (cls_req_i),
    .grant_o (grant)
  );

  exc_target_calc #(
    .ADDR_W     (ADDR_W),
    .NUM_CLS    (NUM_CLS),
    .ALIGN_BITS (ALIGN_BITS),
    .BOOT_VEC   (BOOT_VEC),
    .BEV_OVF    (BEV_OVF)
  ) i_calc (
    .grant_i    (grant),
    .boot_i     (boot_req_i),
    .bev_i      (bev_i),
    .exl_prev_i (exl_prev_i),
    .ivec_en_i  (ivec_en_i),
    .base_i     (exc_base_i),
    .target_o   (target)
  );

  exc_vec_reg #(
    .ADDR_W     (ADDR_W),
    .INSN_BYTES (INSN_BYTES),
    .RESET_PC   (BOOT_VEC)
  ) i_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .target_i   (target),
    .pc_o       (handler_pc_o),
    .pc1_o      (fetch_pc1_o),
    .pc2_o      (fetch_pc2_o),
    .redirect_o (redirect_o)
  );

  initial begin
    a_r2_min_classes: assert (NUM_CLS >= MIN_CLS);
  end

  a_r1_boot_wins: assert property (@(posedge clk) disable iff (!rst_n)
    boot_req_i |=> handler_pc_o == BOOT_VEC);
  a_r5_bev_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_req_i && cls_req_i[CLS_OVF] && !(|cls_req_i[CLS_OVF-1:0]) && bev_i)
    |=> handler_pc_o == BEV_OVF);
  a_r3_refill_base: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_req_i && cls_req_i[CLS_REFILL] && !exl_prev_i)
    |=> handler_pc_o == {$past(exc_base_i[ADDR_W-1:ALIGN_BITS]), {ALIGN_BITS{1'b0}}});
  a_r6_general_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_req_i && cls_req_i[CLS_GEN] && !(|cls_req_i[CLS_GEN-1:0]))
    |=> handler_pc_o[ALIGN_BITS-1:0] == 12'h180);
endmodule

// File: tb/test_exc_vector_sel.sv
module test_exc_vector_sel;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        boot_req_i;
  logic [3:0]  cls_req_i;
  logic        bev_i, exl_prev_i, ivec_en_i;
  logic [31:0] exc_base_i;
  logic [31:0] handler_pc_o, fetch_pc1_o, fetch_pc2_o;
  logic        redirect_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_pc;
  logic        exp_red;

  always #(PERIOD/2) clk = ~clk;

  exc_vector_sel i_exc_vector_sel (
    .clk(clk), .rst_n(rst_n), .boot_req_i(boot_req_i), .cls_req_i(cls_req_i),
    .bev_i(bev_i), .exl_prev_i(exl_prev_i), .ivec_en_i(ivec_en_i),
    .exc_base_i(exc_base_i), .handler_pc_o(handler_pc_o),
    .fetch_pc1_o(fetch_pc1_o), .fetch_pc2_o(fetch_pc2_o), .redirect_o(redirect_o)
  );

  function automatic logic [31:0] model_pc(logic [3:0] rq, logic bt, logic ex,
                                           logic bv, logic ivv, logic [31:0] eb);
    int winner = -1;
    logic [31:0] base = eb & 32'hFFFF_F000;
    if (bt) return 32'hBFC0_0000;
    for (int k = 3; k >= 0; k--) if (rq[k]) winner = k;
    case (winner)
      0: return ex ? base + 32'h180 : base;
      1: return ivv ? base + 32'h200 : base + 32'h180;
      2: return bv ? 32'hBFC0_0200 : base + 32'h180;
      default: return base + 32'h180;
    endcase
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [3:0] rq, logic bt, logic ex, logic bv, logic ivv,
                     logic [31:0] eb, string tag);
    cls_req_i = rq; boot_req_i = bt; exl_prev_i = ex; bev_i = bv;
    ivec_en_i = ivv; exc_base_i = eb;
    exp_red = (rq != 0) || bt;
    if (exp_red) exp_pc = model_pc(rq, bt, ex, bv, ivv, eb);
    @(negedge clk);
    chk(handler_pc_o, exp_pc, tag);
    chk({31'd0, redirect_o}, {31'd0, exp_red}, {tag, " R8 strobe"});
    chk(fetch_pc1_o, exp_pc + 32'd4, "R9 plus4");
    chk(fetch_pc2_o, exp_pc + 32'd8, "R9 plus8");
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; boot_req_i = 0; cls_req_i = 0; bev_i = 0; exl_prev_i = 0;
    ivec_en_i = 0; exc_base_i = 0;
    repeat (3) @(negedge clk);
    chk(handler_pc_o, 32'hBFC0_0000, "R10 reset pc");
    chk({31'd0, redirect_o}, 32'd0, "R10 reset strobe");
    rst_n = 1'b1;
    exp_pc = 32'hBFC0_0000; exp_red = 0;
    @(negedge clk);
    cyc(4'b1111, 1, 1, 1, 1, 32'h8000_1000, "R1 boot over all");
    cyc(4'b0000, 0, 0, 0, 0, 32'h8000_1000, "R8 idle hold");
    cyc(4'b0001, 0, 0, 0, 0, 32'h8000_1000, "R3 refill exl0");
    cyc(4'b0001, 0, 1, 0, 0, 32'h8000_1000, "R3 refill exl1");
    cyc(4'b0010, 0, 0, 0, 1, 32'h8000_3000, "R4 irq iv1");
    cyc(4'b0010, 0, 0, 0, 0, 32'h8000_3000, "R4 irq iv0");
    cyc(4'b0100, 0, 0, 1, 0, 32'h8000_4000, "R5 ovf bev1");
    cyc(4'b0100, 0, 0, 0, 0, 32'h8000_4000, "R5 ovf bev0");
    cyc(4'b1000, 0, 0, 1, 1, 32'h8000_5000, "R6 general mode bits");
    cyc(4'b1000, 0, 0, 0, 0, 32'h8000_2ABC, "R7 base low bits");
    cyc(4'b0001, 0, 0, 0, 0, 32'h8000_6FFF, "R7 refill base low bits");
    cyc(4'b1110, 0, 0, 1, 1, 32'h8000_7000, "R2 irq over ovf");
    cyc(4'b1100, 0, 0, 1, 1, 32'h8000_7000, "R2 ovf over general");
    cyc(4'b1111, 0, 0, 1, 1, 32'h8000_7000, "R2 refill over all");
    cyc(4'b0000, 0, 1, 1, 1, 32'h1234_5000, "R8 idle hold2");
    cyc(4'b0000, 0, 0, 0, 0, 32'h0, "R8 idle hold3");
    for (int n = 0; n < 400; n++) begin
      cyc(4'($urandom), ($urandom % 8) == 0, 1'($urandom), 1'($urandom),
          1'($urandom), $urandom, "R2/R8 random");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule